// File: doc/BRIEF.md
# Gated 16-bit Period Timer

This block is a 16-bit up-counter checked against a programmable period. On the count step after the counter equals the period, it returns to zero and sets a sticky event flag. That flag appears on the interrupt output one clock later. Each count step is a tick from a prescaler that divides the selected source by 1, 8, 64 or 256. There are three sources: every cycle of the main clock; main clock cycles while a gate input is high; or rising edges of an external clock input. The external input is sampled in the main clock domain through a synchronizer chain. A control bit picks either a shorter path or the full three-flop path for that input. In gated mode, a falling edge of the gate also sets the event flag, so software can read the count as a pulse width.

Software uses a single write port and a combinational read port. Address bits [3:2] pick one of four registers. Address bits [1:0] pick how a write is applied: plain write, clear-ones, set-ones or invert-ones. This lets single bits change without a read-modify-write.

A four-state machine holds the operating mode. Its state follows the control register one clock later. ST_IDLE is entered whenever the enable bit is low. ST_RUN_EXT is entered when the enable and source bits are both set. ST_RUN_GATED is entered when enabled, the source bit is clear and the gate-enable bit is set. ST_RUN_INT covers the remaining enabled case. Every state moves directly to any other state when the control bits change.

Top module: `period_timer`

## Requirements
- R1: After reset, the control register reads 0x0000, the count reads 0x0000, the period reads 0xFFFF, the status register reads 0 and irq is low.
- R2: When control bit 15 (enable) is 1 and bits 1 and 7 are 0, the count rises by one on every prescaler tick. The mode takes effect one clock after the control write.
- R3: Control bits [5:4] set the division ratio: code 00 gives 1, 01 gives 8, 10 gives 64 and 11 gives 256 source events per count step.
- R4: On a count step taken while the count equals the period, the count becomes 0 and status bit 0 (event flag) becomes 1. irq equals the event flag delayed by one clock.
- R5: With enable set, bit 1 clear and bit 7 (gate enable) set, only cycles where the synchronized gate_in is high are counted. A falling edge of the synchronized gate sets the event flag.
- R6: With enable and bit 1 (source select) set, the block counts rising edges of ext_clk_in. Bit 7 has no effect and the gate level is ignored.
- R7: Control bit 2 selects the external input path. With it at 1, a rising edge of ext_clk_in is counted one clock later than with it at 0.
- R8: With the enable bit at 0, the count and the prescaler phase hold.
- R9: Any write to the count register, and any control write that changes bits [5:4], restarts the prescaler phase at zero.
- R10: Address bits [3:2] select the register: 0 control, 1 count, 2 period, 3 status. Address bits [1:0] select the write operation: 0 write, 1 clear the bits given as 1, 2 set the bits given as 1, 3 invert the bits given as 1.
- R11: The event flag stays at 1 until software writes status bit 0 to 0.
- R12: Control bits other than 15, 7, 5, 4, 2 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_in | input | 1 | Gate level for gated mode, asynchronous |
| ext_clk_in | input | 1 | External count input, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register select [3:2] and write operation [1:0] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| irq | output | 1 | Registered copy of the event flag |

## Verification
The main counting function is driven in four ways:
- A free-running internal source under all four prescaler codes. This separates the division ratios from one another and shows where the prescaler phase restarts.
- A gate held low, then high for a known number of cycles, then released. The final count shows that only the high window was counted, and the flag shows that the falling edge was seen.
- Slow square pulses on the external input with the gate-enable bit set and the gate held low. This shows that the gate is ignored in external mode.
- The same pulses with both path settings. Per-clock comparison against a behavioural model exposes the one-clock latency difference.

A short period shows the wrap point and the flag and interrupt timing. A disabled interval shows that the count holds.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int BUS_W = 16;

    // control bit positions, decoded by the mode logic
    localparam int BIT_ON    = 15;
    localparam int BIT_GATE  = 7;
    localparam int BIT_PS_HI = 5;
    localparam int BIT_PS_LO = 4;
    localparam int BIT_SYNC  = 2;
    localparam int BIT_SRC   = 1;

    localparam logic [BUS_W-1:0] CTRL_MASK = 16'h80B6;
    localparam logic [BUS_W-1:0] PERIOD_RST = 16'hFFFF;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_CLR   = 2'd1,
        OP_SET   = 2'd2,
        OP_INV   = 2'd3
    } wr_op_e;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RUN_INT   = 2'd1,
        ST_RUN_GATED = 2'd2,
        ST_RUN_EXT   = 2'd3
    } tmr_state_e;

    function automatic logic [BUS_W-1:0] apply_op(
        input wr_op_e           op,
        input logic [BUS_W-1:0] cur,
        input logic [BUS_W-1:0] wd
    );
        logic [BUS_W-1:0] res;
        unique case (op)
            OP_WRITE: res = wd;
            OP_CLR:   res = cur & ~wd;
            OP_SET:   res = cur | wd;
            OP_INV:   res = cur ^ wd;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/ptmr_edge_sync.sv
module ptmr_edge_sync #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    input  logic early,
    output logic rise
);
    localparam int TAP_A = DEPTH - 3;
    localparam int TAP_B = DEPTH - 2;
    localparam int TAP_C = DEPTH - 1;

    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[DEPTH-2:0], d};
        end
    end

    // early path skips one flop of latency; late path uses full chain
    assign rise = early ? (chain[TAP_A] & ~chain[TAP_B])
                        : (chain[TAP_B] & ~chain[TAP_C]);

endmodule

// File: rtl/ptmr_level_sync.sv
module ptmr_level_sync #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic lvl,
    output logic fall
);
    localparam int TAP_B = DEPTH - 2;
    localparam int TAP_C = DEPTH - 1;

    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[DEPTH-2:0], d};
        end
    end

    assign lvl  = chain[TAP_B];
    assign fall = ~chain[TAP_B] & chain[TAP_C];

endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int CW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code,
    input  logic       pulse,
    input  logic       clr,
    output logic       tick
);
    localparam logic [CW:0] RATIO_MAX = (CW+1)'(1) << CW;

    logic [CW:0]   ratio;
    logic [CW-1:0] pcnt;
    logic          last;

    always_comb begin
        unique case (code)
            2'd0: ratio = (CW+1)'(1);
            2'd1: ratio = (CW+1)'(8);
            2'd2: ratio = (CW+1)'(64);
            2'd3: ratio = RATIO_MAX;
        endcase
    end

    assign last = ({1'b0, pcnt} == (ratio - 1'b1));
    assign tick = pulse & last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clr) begin
            pcnt <= '0;
        end else if (pulse) begin
            pcnt <= last ? '0 : pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int W = ptmr_pkg::BUS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] period,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         evt_extra,
    input  logic         flag_wr,
    input  logic         flag_wval,
    output logic [W-1:0] cnt,
    output logic         flag,
    output logic         irq_q
);
    logic at_top;
    logic wrap;

    assign at_top = (cnt == period);
    assign wrap   = tick & at_top;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= at_top ? '0 : cnt + 1'b1;
        end
    end

    // hardware events take precedence over a software update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (wrap | evt_extra) begin
            flag <= 1'b1;
        end else if (flag_wr) begin
            flag <= flag_wval;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= flag;
        end
    end

endmodule

// File: rtl/period_timer.sv
module period_timer
    import ptmr_pkg::*;
#(
    parameter int PS_CW      = 8,
    parameter int SYNC_DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_in,
    input  logic             ext_clk_in,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq
);

    reg_sel_e         sel;
    wr_op_e           op;
    logic             ctrl_wr;
    logic             per_wr;
    logic             cnt_wr;
    logic             stat_wr;
    logic [BUS_W-1:0] ctrl_q;
    logic [BUS_W-1:0] ctrl_new;
    logic [BUS_W-1:0] period_q;
    logic [BUS_W-1:0] cnt_q;
    logic [BUS_W-1:0] cnt_new;
    logic             flag_q;
    logic             flag_new;
    logic             ps_chg;
    logic             ps_clr;

    tmr_state_e       state_q;
    tmr_state_e       state_nxt;
    logic             src_pulse;
    logic             gate_evt;
    logic             tick;

    logic             ext_rise;
    logic             gate_lvl;
    logic             gate_fall;

    // ---------------- write decode ----------------
    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign op      = wr_op_e'(bus_addr[1:0]);
    assign ctrl_wr = bus_wr && (sel == SEL_CTRL);
    assign cnt_wr  = bus_wr && (sel == SEL_COUNT);
    assign per_wr  = bus_wr && (sel == SEL_PERIOD);
    assign stat_wr = bus_wr && (sel == SEL_STATUS);

    assign ctrl_new = apply_op(op, ctrl_q, bus_wdata) & CTRL_MASK;
    assign cnt_new  = apply_op(op, cnt_q, bus_wdata);
    assign ps_chg   = ctrl_wr &&
                      (ctrl_new[BIT_PS_HI:BIT_PS_LO] != ctrl_q[BIT_PS_HI:BIT_PS_LO]);
    assign ps_clr   = cnt_wr | ps_chg;

    always_comb begin
        unique case (op)
            OP_WRITE: flag_new = bus_wdata[0];
            OP_CLR:   flag_new = flag_q & ~bus_wdata[0];
            OP_SET:   flag_new = flag_q | bus_wdata[0];
            OP_INV:   flag_new = flag_q ^ bus_wdata[0];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= PERIOD_RST;
        end else if (per_wr) begin
            period_q <= apply_op(op, period_q, bus_wdata);
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        unique case (sel)
            SEL_CTRL:   bus_rdata = ctrl_q;
            SEL_COUNT:  bus_rdata = cnt_q;
            SEL_PERIOD: bus_rdata = period_q;
            SEL_STATUS: bus_rdata = {{(BUS_W-1){1'b0}}, flag_q};
        endcase
    end

    // ---------------- input synchronizers ----------------
    ptmr_edge_sync #(.DEPTH(SYNC_DEPTH)) i_ext_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_clk_in),
        .early (~ctrl_q[BIT_SYNC]),
        .rise  (ext_rise)
    );

    ptmr_level_sync #(.DEPTH(SYNC_DEPTH)) i_gate_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gate_in),
        .lvl   (gate_lvl),
        .fall  (gate_fall)
    );

    // ---------------- mode state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        if (!ctrl_q[BIT_ON]) begin
            state_nxt = ST_IDLE;
        end else if (ctrl_q[BIT_SRC]) begin
            state_nxt = ST_RUN_EXT;
        end else if (ctrl_q[BIT_GATE]) begin
            state_nxt = ST_RUN_GATED;
        end else begin
            state_nxt = ST_RUN_INT;
        end
    end

    always_comb begin
        src_pulse = 1'b0;
        gate_evt  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                src_pulse = 1'b0;
            end
            ST_RUN_INT: begin
                src_pulse = 1'b1;
            end
            ST_RUN_GATED: begin
                src_pulse = gate_lvl;
                gate_evt  = gate_fall;
            end
            ST_RUN_EXT: begin
                src_pulse = ext_rise;
            end
        endcase
    end

    // ---------------- prescaler and counter ----------------
    ptmr_prescale #(.CW(PS_CW)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (ctrl_q[BIT_PS_HI:BIT_PS_LO]),
        .pulse (src_pulse),
        .clr   (ps_clr),
        .tick  (tick)
    );

    ptmr_counter #(.W(BUS_W)) i_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .period    (period_q),
        .load      (cnt_wr),
        .load_val  (cnt_new),
        .evt_extra (gate_evt),
        .flag_wr   (stat_wr),
        .flag_wval (flag_new),
        .cnt       (cnt_q),
        .flag      (flag_q),
        .irq_q     (irq)
    );

endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                cnt_wr,
    input logic                stat_wr,
    input logic                flag_q,
    input logic                irq,
    input logic                gate_lvl,
    input logic [15:0]         cnt_q,
    input logic [15:0]         period_q,
    input ptmr_pkg::tmr_state_e state_q
);
    import ptmr_pkg::*;

    // R2
    int_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_INT && tick && !cnt_wr && cnt_q != period_q)
        |=> cnt_q == $past(cnt_q) + 16'd1);

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == period_q && !cnt_wr) |=> (cnt_q == 16'd0 && flag_q));

    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |=> irq);

    // R4
    irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_q |=> !irq);

    // R5
    gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_GATED && !gate_lvl && !cnt_wr) |=> $stable(cnt_q));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !cnt_wr) |=> $stable(cnt_q));

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !stat_wr) |=> flag_q);

endmodule

bind period_timer ptmr_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cnt_wr   (cnt_wr),
    .stat_wr  (stat_wr),
    .flag_q   (flag_q),
    .irq      (irq),
    .gate_lvl (gate_lvl),
    .cnt_q    (cnt_q),
    .period_q (period_q),
    .state_q  (state_q)
);

// File: tb/test_period_timer.sv
module test_period_timer;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gate_in = 1'b0;
    logic        ext_clk_in = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h4;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string phase = "R1";

    period_timer i_period_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_in    (gate_in),
        .ext_clk_in (ext_clk_in),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq        (irq)
    );

    always #2 clk = ~clk;

    // ---------------- reference model ----------------
    logic        m_e1, m_e2, m_e3, m_g1, m_g2, m_g3;
    int          m_state;
    int          m_pcnt;
    logic [15:0] m_cnt, m_per, m_ctrl;
    logic        m_flag, m_irq;

    function automatic logic [15:0] f_op(input logic [1:0] op,
                                         input logic [15:0] c,
                                         input logic [15:0] d);
        case (op)
            2'd0:    return d;
            2'd1:    return c & ~d;
            2'd2:    return c | d;
            default: return c ^ d;
        endcase
    endfunction

    function automatic int f_ratio(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 8;
            2'd2:    return 64;
            default: return 256;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_e1, m_e2, m_e3, m_g1, m_g2, m_g3} = '0;
            m_state = 0; m_pcnt = 0; m_cnt = 0; m_per = 16'hFFFF;
            m_ctrl = 0; m_flag = 0; m_irq = 0;
        end else begin
            int          ratio, n_pcnt, n_state;
            bit          pulse, tick, rise, gfall, wrap, psclr;
            logic [15:0] n_cnt, n_ctrl, n_per, st_val;
            logic        n_flag;
            logic [1:0]  sel, op;
            sel   = bus_addr[3:2];
            op    = bus_addr[1:0];
            ratio = f_ratio(m_ctrl[5:4]);
            rise  = m_ctrl[2] ? (m_e2 & ~m_e3) : (m_e1 & ~m_e2);
            gfall = ~m_g2 & m_g3;
            case (m_state)
                1:       pulse = 1;
                2:       pulse = m_g2;
                3:       pulse = rise;
                default: pulse = 0;
            endcase
            tick = pulse && (m_pcnt == ratio - 1);
            wrap = tick && (m_cnt == m_per);
            n_ctrl = (bus_wr && sel == 0) ? (f_op(op, m_ctrl, bus_wdata) & 16'h80B6) : m_ctrl;
            n_per  = (bus_wr && sel == 2) ? f_op(op, m_per, bus_wdata) : m_per;
            if (bus_wr && sel == 1) n_cnt = f_op(op, m_cnt, bus_wdata);
            else if (tick)          n_cnt = (m_cnt == m_per) ? 16'h0 : m_cnt + 16'h1;
            else                    n_cnt = m_cnt;
            psclr = (bus_wr && sel == 1) || (bus_wr && sel == 0 && n_ctrl[5:4] != m_ctrl[5:4]);
            if (psclr)      n_pcnt = 0;
            else if (pulse) n_pcnt = (m_pcnt == ratio - 1) ? 0 : m_pcnt + 1;
            else            n_pcnt = m_pcnt;
            st_val = f_op(op, {15'h0, m_flag}, bus_wdata);
            if (wrap || (m_state == 2 && gfall)) n_flag = 1;
            else if (bus_wr && sel == 3)         n_flag = st_val[0];
            else                                 n_flag = m_flag;
            if (!m_ctrl[15])     n_state = 0;
            else if (m_ctrl[1])  n_state = 3;
            else if (m_ctrl[7])  n_state = 2;
            else                 n_state = 1;
            m_irq = m_flag;
            m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_clk_in;
            m_g3 = m_g2; m_g2 = m_g1; m_g1 = gate_in;
            m_state = n_state; m_pcnt = n_pcnt; m_cnt = n_cnt;
            m_ctrl = n_ctrl; m_per = n_per; m_flag = n_flag;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(irq === m_irq, phase, "irq vs model", irq, m_irq);
            if (!bus_wr && bus_addr == 4'h4)
                check(bus_rdata === m_cnt, phase, "count vs model", bus_rdata, m_cnt);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); #0.5;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #0.5;
        bus_wr = 1'b0; bus_addr = 4'h4;
    endtask

    task automatic read_val(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk); #0.5;
        bus_addr = a;
        #0.5;
        v = bus_rdata;
        bus_addr = 4'h4;
    endtask

    task automatic read_chk(input logic [3:0] a, input logic [15:0] exp,
                            input string tag, input string what);
        logic [15:0] v;
        read_val(a, v);
        check(v === exp, tag, what, v, exp);
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #0.5; ext_clk_in = 1'b1;
            wait_clks(3);
            #0.5; ext_clk_in = 1'b0;
            wait_clks(3);
        end
    endtask

    // ---------------- test sequence ----------------
    initial begin
        logic [15:0] a_val, b_val;
        wait_clks(3);
        #0.5; rst_n = 1'b1;
        wait_clks(1);

        // R1 reset state
        read_chk(4'h0, 16'h0000, "R1", "ctrl reset");
        read_chk(4'h4, 16'h0000, "R1", "count reset");
        read_chk(4'h8, 16'hFFFF, "R1", "period reset");
        read_chk(4'hC, 16'h0000, "R1", "status reset");
        check(irq === 1'b0, "R1", "irq reset", irq, 0);

        // R12 unimplemented control bits, R10 aliases on period
        phase = "R12";
        bus_write(4'h0, 16'h7F49);
        read_chk(4'h0, 16'h0000, "R12", "ctrl reserved bits");
        phase = "R10";
        bus_write(4'h8, 16'h1234);
        bus_write(4'hA, 16'h00F0);
        read_chk(4'h8, 16'h12F4, "R10", "set alias");
        bus_write(4'h9, 16'h0204);
        read_chk(4'h8, 16'h10F0, "R10", "clear alias");
        bus_write(4'hB, 16'hFFFF);
        read_chk(4'h8, 16'hEF0F, "R10", "invert alias");

        // R2 internal count, R4 wrap with period 5
        phase = "R2";
        bus_write(4'h8, 16'h0005);
        bus_write(4'h4, 16'h0000);
        bus_write(4'h0, 16'h8000);
        wait_clks(20);
        phase = "R4";
        read_chk(4'hC, 16'h0001, "R4", "flag after wrap");
        check(irq === 1'b1, "R4", "irq after wrap", irq, 1);

        // R8 disable holds count
        phase = "R8";
        bus_write(4'h1, 16'h8000);
        wait_clks(2);
        read_val(4'h4, a_val);
        wait_clks(10);
        read_val(4'h4, b_val);
        check(a_val === b_val, "R8", "count held while disabled", b_val, a_val);

        // R11 flag sticky until cleared
        phase = "R11";
        read_chk(4'hC, 16'h0001, "R11", "flag still set");
        bus_write(4'hD, 16'h0001);
        wait_clks(2);
        read_chk(4'hC, 16'h0000, "R11", "flag after clear");
        check(irq === 1'b0, "R11", "irq after clear", irq, 0);

        // R3 prescaler ratios
        phase = "R3";
        bus_write(4'h8, 16'hFFFF);
        bus_write(4'h0, 16'h8010);
        bus_write(4'h4, 16'h0000);
        wait_clks(40);
        bus_write(4'h0, 16'h8020);
        wait_clks(200);
        bus_write(4'h0, 16'h8030);
        wait_clks(600);
        read_chk(4'h4, m_cnt, "R3", "count at div 256");
        // R9 count write restarts prescaler phase
        phase = "R9";
        bus_write(4'h4, 16'h0000);
        wait_clks(300);
        bus_write(4'h0, 16'h8010);
        wait_clks(30);
        read_chk(4'h4, m_cnt, "R9", "count after phase restart");

        // R5 gated counting
        phase = "R5";
        bus_write(4'h0, 16'h8080);
        bus_write(4'h4, 16'h0000);
        bus_write(4'hD, 16'h0001);
        wait_clks(10);
        read_chk(4'h4, 16'h0000, "R5", "no count while gate low");
        @(negedge clk); #0.5; gate_in = 1'b1;
        wait_clks(10);
        #0.5; gate_in = 1'b0;
        wait_clks(6);
        read_chk(4'h4, 16'd10, "R5", "count equals gate width");
        read_chk(4'hC, 16'h0001, "R5", "flag on gate fall");

        // R6 external edges, gate bit ignored
        phase = "R6";
        bus_write(4'h0, 16'h8082);
        bus_write(4'h4, 16'h0000);
        ext_pulses(7);
        wait_clks(5);
        read_chk(4'h4, 16'd7, "R6", "external edges counted");

        // R7 full synchronizer path
        phase = "R7";
        bus_write(4'h0, 16'h8086);
        bus_write(4'h4, 16'h0000);
        ext_pulses(7);
        wait_clks(5);
        read_chk(4'h4, 16'd7, "R7", "edges counted on full path");

        // R4 short period wrap
        phase = "R4";
        bus_write(4'h0, 16'h0000);
        bus_write(4'h8, 16'h0003);
        bus_write(4'h4, 16'h0000);
        bus_write(4'hD, 16'h0001);
        bus_write(4'h0, 16'h8000);
        wait_clks(3);
        read_chk(4'hC, 16'h0000, "R4", "no flag before wrap");
        wait_clks(10);
        read_chk(4'hC, 16'h0001, "R4", "flag after period 3 wrap");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog %s run did not finish", phase);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule